// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block is the digital controller for a successive-approximation converter with a 12-bit default resolution. It accepts single and scan conversion requests from trigger pulses or from per-mode repeat bits. It derives a conversion tick from the system clock through a programmable divider and walks each conversion through three phases on that tick. The first is an optional warm-up. The second is acquisition. The third is one bit decision per tick against an external comparator, followed by a final tick that publishes the result.

The analog side is represented only by handshakes. The block drives a trial code and a one-cycle strobe for each bit decision. The comparator answers on `cmp_i`, high when the input is at or above the trial code. Power-enable outputs tell the analog domain when the converter core and the reference must be on. Scan requests win over single requests. Triggers that arrive while the block is busy are held until they can be served.

Top module: `sar_seq`

## Requirements
- R1: The tick period is `presc_i`+1 clock cycles, for `presc_i` from 0 to 127. From a start out of idle, the done pulse appears T·(`presc_i`+1) cycles after the start edge, and the start edge is the clock edge after the trigger is sampled.
- R2: Acquisition lasts 2^min(at,8) ticks, with `acq_o` high for exactly that many ticks. Single conversions use `single_at_i` and scan conversions use `scan_at_i`.
- R3: A conversion takes T = W + A + N + 1 ticks, where W is the warm-up, A the acquisition and N the resolution. `done_o` is a one-cycle pulse and the state moves only on ticks.
- R4: The warm-up W depends on `wu_mode_i`, with one microsecond equal to `timebase_i`+1 ticks. Mode 0 gives 5 µs, mode 1 gives 1 µs, mode 2 gives 0, and mode 3 behaves as mode 0. Warm-up applies only to a conversion started from idle.
- R5: While busy, `pwr_adc_o` and `pwr_ref_o` are both 1. In idle, `pwr_ref_o` is 1 for modes 1 and 2, and `pwr_adc_o` is 1 only for mode 2.
- R6: Each conversion issues exactly N strobes, MSB first. `trial_o` equals the bits already decided with the current bit set. `result_o` holds the comparator decisions, so a comparator that tests `vin >= trial_o` yields `vin`.
- R7: When both kinds of request are pending, the scan conversion runs first. `done_scan_o` is 1 for a scan result and 0 for a single result.
- R8: If the repeat bit of the finishing mode is 1 at its final tick, a new conversion of that mode starts at once with no warm-up. The next done follows (A+N+1)·D cycles later, where D is the tick period in cycles.
- R9: A trigger that arrives during a busy conversion is kept. Its conversion starts directly after the current one, with no warm-up.
- R10: The divider, acquisition and warm-up settings are captured only when the block leaves idle. Changing them while busy does not alter the timing of the running conversion or of any conversion chained to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_i | input | 7 | Tick divider minus one |
| timebase_i | input | 8 | Ticks per microsecond minus one |
| wu_mode_i | input | 2 | Warm-up policy (0 normal, 1 standby, 2 keep warm) |
| single_at_i | input | 4 | Single acquisition exponent |
| scan_at_i | input | 4 | Scan acquisition exponent |
| single_trig_i | input | 1 | Single request pulse |
| scan_trig_i | input | 1 | Scan request pulse |
| single_rep_i | input | 1 | Repeat single conversions |
| scan_rep_i | input | 1 | Repeat scan conversions |
| cmp_i | input | 1 | Comparator answer for the current trial |
| cmp_strobe_o | output | 1 | Bit-decision strobe |
| trial_o | output | 12 | Trial code presented to the DAC |
| acq_o | output | 1 | Acquisition phase active |
| pwr_adc_o | output | 1 | Converter core enable |
| pwr_ref_o | output | 1 | Reference enable |
| done_o | output | 1 | Conversion complete pulse |
| done_scan_o | output | 1 | Completed conversion was a scan |
| result_o | output | 12 | Last conversion result |

## Verification
The assertions assume that trigger inputs are synchronous single-cycle pulses. They also assume that `cmp_i` is a settled function of `trial_o` whenever a strobe is issued. The bench meets both conditions. It drives all inputs at falling edges and models the comparator as a continuous compare between a held input value and `trial_o`. Random settings stay within the encoded ranges, with acquisition exponents up to 9 so that the clamp is exercised. Each conversion starts from idle unless a test deliberately chains one through repeat, retrigger or simultaneous requests.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_WARM, ST_ACQ, ST_CONV, ST_FIN} phase_e;
  localparam logic [1:0] WU_NORMAL  = 2'd0;
  localparam logic [1:0] WU_STANDBY = 2'd1;
  localparam logic [1:0] WU_KEEP    = 2'd2;
  localparam int AT_MAX = 8;
endpackage

// File: rtl/sar_seq_presc.sv
module sar_seq_presc #(
  parameter int PW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_seq_arb.sv
module sar_seq_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_single_i,
  input  logic trig_scan_i,
  input  logic rep_single_i,
  input  logic rep_scan_i,
  input  logic take_i,
  output logic avail_o,
  output logic gnt_scan_o
);
  logic pend_single_q, pend_scan_q;
  logic av_single, av_scan;

  assign av_scan    = pend_scan_q | rep_scan_i;
  assign av_single  = pend_single_q | rep_single_i;
  assign gnt_scan_o = av_scan;
  assign avail_o    = av_scan | av_single;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_single_q <= 1'b0;
      pend_scan_q   <= 1'b0;
    end else begin
      // a new trigger always survives a same-cycle grant
      pend_scan_q   <= (av_scan & ~take_i) | trig_scan_i;
      pend_single_q <= (av_single & ~(take_i & ~av_scan)) | trig_single_i;
    end
  end

  assert_trig_kept_scan_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_scan_i |=> pend_scan_q);
  assert_trig_kept_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_single_i |=> pend_single_q);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int N    = 12,
  parameter int PW   = 7,
  parameter int TB_W = 8,
  parameter int AT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PW-1:0]   presc_i,
  input  logic [TB_W-1:0] timebase_i,
  input  logic [1:0]      wu_mode_i,
  input  logic [AT_W-1:0] single_at_i,
  input  logic [AT_W-1:0] scan_at_i,
  input  logic            single_trig_i,
  input  logic            scan_trig_i,
  input  logic            single_rep_i,
  input  logic            scan_rep_i,
  input  logic            cmp_i,
  output logic            cmp_strobe_o,
  output logic [N-1:0]    trial_o,
  output logic            acq_o,
  output logic            pwr_adc_o,
  output logic            pwr_ref_o,
  output logic            done_o,
  output logic            done_scan_o,
  output logic [N-1:0]    result_o
);
  localparam int BW     = $clog2(N);
  localparam int SCW    = $clog2(N + 1);
  localparam int WU_MAX = 5 * (2 ** TB_W);
  localparam int LW     = ($clog2(WU_MAX + 1) > AT_MAX + 1) ? $clog2(WU_MAX + 1) : AT_MAX + 2;

  phase_e          state_q;
  logic [LW-1:0]   left_q;
  logic [BW-1:0]   bit_q;
  logic [N-1:0]    sar_q, res_q;
  logic            done_q, done_scan_q, cur_scan_q;
  logic [PW-1:0]   presc_q;
  logic [AT_W-1:0] at_single_q, at_scan_q;
  logic [SCW-1:0]  strb_cnt_q;

  logic tick, idle, fin_tick, take, avail, gnt_scan;
  logic rep_single, rep_scan;
  logic [AT_W-1:0] at_next;
  logic [LW-1:0]   acq_next, acq_cur, us_len, warm_len;

  function automatic logic [LW-1:0] acq_ticks(input logic [AT_W-1:0] a);
    logic [AT_W-1:0] c;
    c = (a > AT_W'(AT_MAX)) ? AT_W'(AT_MAX) : a;
    return LW'(1) << c;
  endfunction

  assign idle     = (state_q == ST_IDLE);
  assign fin_tick = (state_q == ST_FIN) && tick;
  assign rep_scan   = fin_tick & cur_scan_q & scan_rep_i;
  assign rep_single = fin_tick & ~cur_scan_q & single_rep_i;
  assign take     = (idle | fin_tick) & avail;

  sar_seq_presc #(.PW(PW)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!idle),
    .div_i  (presc_q),
    .tick_o (tick)
  );

  sar_seq_arb i_arb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trig_single_i (single_trig_i),
    .trig_scan_i   (scan_trig_i),
    .rep_single_i  (rep_single),
    .rep_scan_i    (rep_scan),
    .take_i        (take),
    .avail_o       (avail),
    .gnt_scan_o    (gnt_scan)
  );

  // settings come from the ports only when leaving idle
  assign at_next  = gnt_scan ? (idle ? scan_at_i : at_scan_q) : (idle ? single_at_i : at_single_q);
  assign acq_next = acq_ticks(at_next);
  assign acq_cur  = acq_ticks(cur_scan_q ? at_scan_q : at_single_q);
  assign us_len   = LW'(timebase_i) + LW'(1);

  always_comb begin
    warm_len = '0;
    if (idle) begin
      case (wu_mode_i)
        WU_STANDBY: warm_len = us_len;
        WU_KEEP:    warm_len = '0;
        default:    warm_len = (us_len << 2) + us_len;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      left_q      <= '0;
      bit_q       <= '0;
      sar_q       <= '0;
      res_q       <= '0;
      done_q      <= 1'b0;
      done_scan_q <= 1'b0;
      cur_scan_q  <= 1'b0;
      presc_q     <= '0;
      at_single_q <= '0;
      at_scan_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        case (state_q)
          ST_WARM: begin
            if (left_q == '0) begin
              state_q <= ST_ACQ;
              left_q  <= acq_cur - LW'(1);
            end else left_q <= left_q - 1'b1;
          end
          ST_ACQ: begin
            if (left_q == '0) begin
              state_q <= ST_CONV;
              bit_q   <= BW'(N - 1);
            end else left_q <= left_q - 1'b1;
          end
          ST_CONV: begin
            sar_q[bit_q] <= cmp_i;
            if (bit_q == '0) state_q <= ST_FIN;
            else             bit_q   <= bit_q - 1'b1;
          end
          default: ;
        endcase
      end
      if (fin_tick) begin
        done_q      <= 1'b1;
        done_scan_q <= cur_scan_q;
        res_q       <= sar_q;
        state_q     <= ST_IDLE;
      end
      if (take) begin
        if (idle) begin
          presc_q     <= presc_i;
          at_single_q <= single_at_i;
          at_scan_q   <= scan_at_i;
        end
        cur_scan_q <= gnt_scan;
        sar_q      <= '0;
        if (warm_len != '0) begin
          state_q <= ST_WARM;
          left_q  <= warm_len - LW'(1);
        end else begin
          state_q <= ST_ACQ;
          left_q  <= acq_next - LW'(1);
        end
      end
    end
  end

  assign cmp_strobe_o = (state_q == ST_CONV) && tick;
  assign trial_o      = (state_q == ST_CONV) ? (sar_q | (N'(1) << bit_q)) : sar_q;
  assign acq_o        = (state_q == ST_ACQ);
  assign pwr_adc_o    = !idle || (wu_mode_i == WU_KEEP);
  assign pwr_ref_o    = !idle || (wu_mode_i == WU_KEEP) || (wu_mode_i == WU_STANDBY);
  assign done_o       = done_q;
  assign done_scan_o  = done_scan_q;
  assign result_o     = res_q;

  // strobe tally for the per-conversion check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           strb_cnt_q <= '0;
    else if (fin_tick)     strb_cnt_q <= '0;
    else if (cmp_strobe_o) strb_cnt_q <= strb_cnt_q + 1'b1;
  end

  assert_state_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !tick) |=> $stable(state_q));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_strobe_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_tick |-> (strb_cnt_q == SCW'(N)));
  assert_scan_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && gnt_scan) |=> cur_scan_q);
  assert_settings_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && $past(!idle)) |-> ($stable(presc_q) && $stable(at_scan_q) && $stable(at_single_q)));
endmodule

// File: tb/test_sar_seq.sv
module test_sar_seq;
  localparam int N = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [6:0] presc = '0;
  logic [7:0] tb = '0;
  logic [1:0] mode = '0;
  logic [3:0] single_at = '0, scan_at = '0;
  logic single_trig = 1'b0, scan_trig = 1'b0, single_rep = 1'b0, scan_rep = 1'b0;
  logic cmp, strobe, acq, pwr_adc, pwr_ref, done, done_scan;
  logic [N-1:0] trial, result, vin;

  int total = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  assign cmp = (vin >= trial);

  sar_seq i_sar_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .presc_i(presc), .timebase_i(tb), .wu_mode_i(mode),
    .single_at_i(single_at), .scan_at_i(scan_at), .single_trig_i(single_trig),
    .scan_trig_i(scan_trig), .single_rep_i(single_rep), .scan_rep_i(scan_rep),
    .cmp_i(cmp), .cmp_strobe_o(strobe), .trial_o(trial), .acq_o(acq),
    .pwr_adc_o(pwr_adc), .pwr_ref_o(pwr_ref), .done_o(done), .done_scan_o(done_scan),
    .result_o(result)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int warm_of(input int m, input int t);
    if (m == 1) return t + 1;
    if (m == 2) return 0;
    return 5 * (t + 1);
  endfunction

  function automatic int acq_of(input int a);
    return 1 << ((a > 8) ? 8 : a);
  endfunction

  task automatic pulse(input bit sc, input bit si);
    @(negedge clk_i);
    scan_trig = sc; single_trig = si;
    @(negedge clk_i);
    scan_trig = 1'b0; single_trig = 1'b0;
  endtask

  task automatic wait_done(output int m);
    m = 0;
    do begin
      @(negedge clk_i);
      m++;
    end while (!done && m < 40000);
  endtask

  task automatic quiet(input string req, input int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      if (done) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic do_check(input bit sc, input int p, input int a, input int other_a,
                          input int m, input int t, input int v, input bit disturb);
    int lat, acqc, strc, d, w, aa;
    bit pa, pr;
    @(negedge clk_i);
    presc = 7'(p); tb = 8'(t); mode = 2'(m); vin = N'(v);
    if (sc) begin scan_at = 4'(a); single_at = 4'(other_a); end
    else begin single_at = 4'(a); scan_at = 4'(other_a); end
    scan_trig = sc; single_trig = !sc;
    @(negedge clk_i);
    scan_trig = 1'b0; single_trig = 1'b0;
    lat = 1; acqc = 0; strc = 0; pa = 0; pr = 0;
    while (!done && lat < 40000) begin
      @(negedge clk_i);
      lat++;
      if (acq) acqc++;
      if (strobe) strc++;
      if (lat == 3) begin pa = pwr_adc; pr = pwr_ref; end
      if (disturb && lat == 5) begin
        presc = 7'd0; tb = 8'd0; mode = 2'd2; scan_at = 4'd0; single_at = 4'd0;
      end
    end
    d = p + 1; w = warm_of(m, t); aa = acq_of(a);
    chk(disturb ? "R10 latency" : "R1 R3 R4 latency", lat, 2 + (w + aa + N + 1) * d);
    chk("R2 acquisition cycles", acqc, aa * d);
    chk("R6 strobe count", strc, N);
    chk("R6 result", int'(result), v);
    chk("R7 done_scan", int'(done_scan), int'(sc));
    chk("R5 busy power", int'({pa, pr}), 3);
    @(negedge clk_i);
    chk("R5 idle adc power", int'(pwr_adc), int'(mode == 2'd2));
    chk("R5 idle ref power", int'(pwr_ref), int'(mode == 2'd2 || mode == 2'd1));
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    int m, lat, s;
    vin = '0;
    s = $urandom(32'h1f2e);
    repeat (3) @(negedge clk_i);
    chk("R3 reset done", int'(done), 0);
    chk("R5 reset power", int'({pwr_adc, pwr_ref}), 0);
    rst_ni = 1'b1;

    // R1 divider extremes, R4 each warm-up mode, R2 clamp
    do_check(1'b0, 0, 0, 5, 2, 0, 12'hABC, 1'b0);
    do_check(1'b1, 127, 0, 3, 2, 0, 12'h000, 1'b0);
    do_check(1'b1, 2, 3, 0, 0, 2, 12'hFFF, 1'b0);
    do_check(1'b0, 1, 1, 7, 1, 3, 12'h800, 1'b0);
    do_check(1'b0, 0, 9, 0, 3, 1, 12'h7FF, 1'b0);
    // R10 settings changed mid-conversion
    do_check(1'b1, 3, 2, 2, 0, 1, 12'h5A5, 1'b1);

    // R7 simultaneous requests
    @(negedge clk_i);
    presc = 7'd1; mode = 2'd2; scan_at = 4'd1; single_at = 4'd3; vin = 12'h321;
    pulse(1'b1, 1'b1);
    wait_done(m);
    chk("R7 scan first latency", 1 + m, 2 + (2 + N + 1) * 2);
    chk("R7 scan first flag", int'(done_scan), 1);
    wait_done(m);
    chk("R7 single second gap", m, (8 + N + 1) * 2);
    chk("R7 single second flag", int'(done_scan), 0);
    chk("R7 result", int'(result), 12'h321);

    // R8 repeat
    @(negedge clk_i);
    presc = 7'd0; mode = 2'd0; tb = 8'd0; scan_at = 4'd0; scan_rep = 1'b1; vin = 12'h0F0;
    pulse(1'b1, 1'b0);
    wait_done(m);
    chk("R8 first latency", 1 + m, 2 + (5 + 1 + N + 1));
    scan_rep = 1'b0;
    wait_done(m);
    chk("R8 repeat gap", m, 1 + N + 1);
    chk("R8 repeat flag", int'(done_scan), 1);
    quiet("R8 stops after repeat cleared", 40);
    chk("R8 idle ref off", int'(pwr_ref), 0);

    // R9 retrigger while busy
    @(negedge clk_i);
    mode = 2'd2; single_at = 4'd2; vin = 12'h9C3;
    pulse(1'b0, 1'b1);
    lat = 1;
    for (int i = 0; i < 5; i++) begin @(negedge clk_i); lat++; end
    single_trig = 1'b1;
    @(negedge clk_i);
    single_trig = 1'b0;
    lat++;
    wait_done(m);
    chk("R9 first latency", lat + m, 2 + (4 + N + 1));
    wait_done(m);
    chk("R9 held trigger gap", m, 4 + N + 1);
    chk("R9 result", int'(result), 12'h9C3);
    quiet("R9 no extra conversion", 40);

    // random mix
    for (int k = 0; k < 20; k++) begin
      do_check(1'($urandom_range(1)), int'($urandom_range(7)), int'($urandom_range(9)),
               int'($urandom_range(9)), int'($urandom_range(3)), int'($urandom_range(7)),
               int'($urandom_range(4095)), 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule